// File: doc/BRIEF.md
# Convolution Accumulator Transfer Unit

This unit keeps a square array of 32-bit convolution accumulators and moves whole vector registers between that array and the vector register file. The array has N rows of N words, where N is the vector width in bits divided by 32, so a 256-bit vector gives an 8-by-8 array. Accumulation arithmetic is not part of this block.

A load command pulls N consecutive source registers from an aligned base, one register per beat, and places them in the array either row by row or transposed. A drain command pushes every row out to a fixed window of destination registers, one row per beat, and zeroes each row once it has been handed over. Register data enters on a valid/ready read stream and leaves on a valid/ready write stream. On the read stream a beat is taken only when `rd_valid` and `rd_ready` are both high. On the write stream `wr_valid`, `wr_idx` and `wr_data` stay fixed until `wr_ready` is seen. Either stream can stall for any number of cycles without losing or skipping a register. Commands use a plain valid/ready pair that is ready only while the unit is idle.

Top module: `acc_xfer`

## Requirements
- R1: After reset every accumulator word is zero, `cmd_ready` is 1, and `done`, `err`, `rd_ready` and `wr_valid` are 0.
- R2: A command is taken only on a cycle where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 1 only while idle, and while idle neither stream is active (`rd_ready`=0, `wr_valid`=0).
- R3: For a load with `cmd_transpose`=0, beat r requests register `rd_idx` = base + r, for r = 0 to N-1 in ascending order. Word i of `rd_data` (bits 32i+31 down to 32i) goes to row r, word i.
- R4: For a load with `cmd_transpose`=1, word i of the register taken on beat r goes to row i, word r.
- R5: A drain (`cmd_get`=1) presents row r on beat r, with `wr_idx` = 48 + r and word i of the row in bits 32i+31 down to 32i of `wr_data`, for r = 0 to N-1 in ascending order.
- R6: Each row is cleared to zero on the same edge that its drain beat is accepted. A second drain with no load in between returns all zeros.
- R7: A load base must be a multiple of 16. A load with a misaligned base pulses `err` for one cycle, in the cycle after it is taken. It makes no read request, leaves the array unchanged and produces no `done`.
- R8: `done` is high for exactly one cycle, the cycle after the final beat, and the unit is idle in that same cycle.
- R9: Read back-pressure: a cycle with `rd_valid`=0 holds `rd_idx` and the beat count, and skips no register.
- R10: Write back-pressure: while `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_idx` and `wr_data` keep their values into the next cycle.
- R11: When neither stream stalls, a transfer finishes in exactly N beat cycles, one register per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Unit idle, command will be taken |
| cmd_get | input | 1 | 1 selects drain, 0 selects load |
| cmd_transpose | input | 1 | Load places registers as columns |
| cmd_base | input | RIDX_W (6) | Source register base for a load |
| rd_idx | output | RIDX_W (6) | Register wanted on the read stream |
| rd_valid | input | 1 | Read data present |
| rd_ready | output | 1 | Unit will take read data |
| rd_data | input | VLEN (256) | Source register contents |
| wr_valid | output | 1 | Write data present |
| wr_ready | input | 1 | Register file takes write data |
| wr_idx | output | RIDX_W (6) | Destination register of the write beat |
| wr_data | output | VLEN (256) | Accumulator row being written out |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| err | output | 1 | One-cycle pulse for a misaligned load |

## Verification
The bench builds the unit with its default 256-bit vector, which gives an 8-by-8 array, 6-bit register indices and a destination window of 48 to 55. At this size a load at base 0, 16 or 32 reaches every row and column index, and the distinct patterns per register and per word make any wrong row/column swap visible. A base of 17 exercises the alignment check. Stall cycles on both streams are placed in the middle of a transfer, so the bench can see whether a stall holds the beat or skips a register.

// File: rtl/acx_pkg.sv
package acx_pkg;
  typedef enum logic [1:0] {
    ACX_IDLE  = 2'd0,
    ACX_LOAD  = 2'd1,
    ACX_DRAIN = 2'd2
  } acx_state_e;
endpackage

// File: rtl/acx_array.sv
module acx_array #(
  parameter int N      = 8,
  parameter int WORD_W = 32,
  localparam int IW    = (N > 1) ? $clog2(N) : 1,
  localparam int ROW_W = N * WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic             ld_transpose,
  input  logic [IW-1:0]    ld_sel,
  input  logic [ROW_W-1:0] ld_data,
  input  logic             clr_en,
  input  logic [IW-1:0]    clr_sel,
  input  logic [IW-1:0]    rd_sel,
  output logic [ROW_W-1:0] rd_row
);

  logic [ROW_W-1:0] rows [N];

  for (genvar r = 0; r < N; r++) begin : g_row
    logic [ROW_W-1:0] row_q;
    logic             row_clr;
    logic             row_ld;

    assign row_clr = clr_en && (clr_sel == IW'(r));
    assign row_ld  = ld_en && !ld_transpose && (ld_sel == IW'(r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else begin
        for (int c = 0; c < N; c++) begin
          if (row_clr) begin
            row_q[c*WORD_W +: WORD_W] <= '0;
          end else if (row_ld) begin
            row_q[c*WORD_W +: WORD_W] <= ld_data[c*WORD_W +: WORD_W];
          end else if (ld_en && ld_transpose && (ld_sel == IW'(c))) begin
            row_q[c*WORD_W +: WORD_W] <= ld_data[r*WORD_W +: WORD_W];
          end
        end
      end
    end

    assign rows[r] = row_q;
  end

  assign rd_row = rows[rd_sel];

endmodule

// File: rtl/acx_seq.sv
module acx_seq
  import acx_pkg::*;
#(
  parameter int N          = 8,
  parameter int RIDX_W     = 6,
  parameter int GET_BASE   = 48,
  parameter int ALIGN_LOG2 = 4,
  localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_get,
  input  logic              cmd_transpose,
  input  logic [RIDX_W-1:0] cmd_base,
  output logic              cmd_ready,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic [RIDX_W-1:0] rd_idx,
  input  logic              wr_ready,
  output logic              wr_valid,
  output logic [RIDX_W-1:0] wr_idx,
  output logic              done,
  output logic              err,
  output logic              ld_en,
  output logic              ld_transpose,
  output logic              clr_en,
  output logic [IW-1:0]     beat
);

  acx_state_e        state_q;
  logic [IW-1:0]     beat_q;
  logic [RIDX_W-1:0] base_q;
  logic              trans_q;
  logic              done_q;
  logic              err_q;
  logic              last_beat;
  logic              misaligned;

  assign last_beat  = (beat_q == IW'(N - 1));
  assign misaligned = (cmd_base[ALIGN_LOG2-1:0] != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ACX_IDLE;
      beat_q  <= '0;
      base_q  <= '0;
      trans_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ACX_IDLE: begin
          if (cmd_valid) begin
            beat_q <= '0;
            if (cmd_get) begin
              state_q <= ACX_DRAIN;
            end else if (misaligned) begin
              err_q <= 1'b1;
            end else begin
              state_q <= ACX_LOAD;
              base_q  <= cmd_base;
              trans_q <= cmd_transpose;
            end
          end
        end
        ACX_LOAD: begin
          if (rd_valid) begin
            if (last_beat) begin
              state_q <= ACX_IDLE;
              beat_q  <= '0;
              done_q  <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ACX_DRAIN: begin
          if (wr_ready) begin
            if (last_beat) begin
              state_q <= ACX_IDLE;
              beat_q  <= '0;
              done_q  <= 1'b1;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        default: state_q <= ACX_IDLE;
      endcase
    end
  end

  assign cmd_ready    = (state_q == ACX_IDLE);
  assign rd_ready     = (state_q == ACX_LOAD);
  assign wr_valid     = (state_q == ACX_DRAIN);
  assign rd_idx       = base_q + RIDX_W'(beat_q);
  assign wr_idx       = RIDX_W'(GET_BASE) + RIDX_W'(beat_q);
  assign ld_en        = rd_ready && rd_valid;
  assign ld_transpose = trans_q;
  assign clr_en       = wr_valid && wr_ready;
  assign beat         = beat_q;
  assign done         = done_q;
  assign err          = err_q;

endmodule

// File: rtl/acc_xfer.sv
module acc_xfer #(
  parameter int VLEN       = 256,
  parameter int WORD_W     = 32,
  parameter int RIDX_W     = 6,
  parameter int GET_BASE   = 48,
  parameter int ALIGN_LOG2 = 4,
  localparam int N         = VLEN / WORD_W,
  localparam int IW        = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_get,
  input  logic              cmd_transpose,
  input  logic [RIDX_W-1:0] cmd_base,
  output logic [RIDX_W-1:0] rd_idx,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [VLEN-1:0]   rd_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [RIDX_W-1:0] wr_idx,
  output logic [VLEN-1:0]   wr_data,
  output logic              done,
  output logic              err
);

  logic          ld_en;
  logic          ld_transpose;
  logic          clr_en;
  logic [IW-1:0] beat;

  acx_seq #(
    .N(N), .RIDX_W(RIDX_W), .GET_BASE(GET_BASE), .ALIGN_LOG2(ALIGN_LOG2)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_get(cmd_get), .cmd_transpose(cmd_transpose),
    .cmd_base(cmd_base), .cmd_ready(cmd_ready),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_idx(rd_idx),
    .wr_ready(wr_ready), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .done(done), .err(err),
    .ld_en(ld_en), .ld_transpose(ld_transpose), .clr_en(clr_en), .beat(beat)
  );

  acx_array #(
    .N(N), .WORD_W(WORD_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_transpose(ld_transpose), .ld_sel(beat), .ld_data(rd_data),
    .clr_en(clr_en), .clr_sel(beat),
    .rd_sel(beat), .rd_row(wr_data)
  );

endmodule

// File: rtl/acc_xfer_chk.sv
module acc_xfer_chk #(
  parameter int VLEN       = 256,
  parameter int RIDX_W     = 6,
  parameter int GET_BASE   = 48,
  parameter int ALIGN_LOG2 = 4,
  parameter int N          = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              cmd_get,
  input logic [RIDX_W-1:0] cmd_base,
  input logic [RIDX_W-1:0] rd_idx,
  input logic              rd_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [RIDX_W-1:0] wr_idx,
  input logic [VLEN-1:0]   wr_data,
  input logic              done,
  input logic              err
);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!rd_ready && !wr_valid));

  assert_read_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |-> (32'(rd_idx[ALIGN_LOG2-1:0]) < N));

  assert_write_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> ((32'(wr_idx) >= GET_BASE) && (32'(wr_idx) < GET_BASE + N)));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(cmd_valid && cmd_ready && !cmd_get &&
                  (cmd_base[ALIGN_LOG2-1:0] != '0)));

  assert_err_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !done);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);

  assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_data)));

endmodule

bind acc_xfer acc_xfer_chk #(
  .VLEN(VLEN), .RIDX_W(RIDX_W), .GET_BASE(GET_BASE),
  .ALIGN_LOG2(ALIGN_LOG2), .N(N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_get(cmd_get), .cmd_base(cmd_base), .rd_idx(rd_idx), .rd_ready(rd_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_data(wr_data),
  .done(done), .err(err)
);

// File: tb/acc_xfer_bench.sv
`timescale 1ns/1ps
module acc_xfer_bench;
  localparam int VLEN = 256;
  localparam int N    = VLEN / 32;
  localparam int GB   = 48;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic            cmd_get = 1'b0;
  logic            cmd_transpose = 1'b0;
  logic [5:0]      cmd_base = '0;
  logic [5:0]      rd_idx;
  logic            rd_valid = 1'b0;
  logic            rd_ready;
  logic [VLEN-1:0] rd_data = '0;
  logic            wr_valid;
  logic            wr_ready = 1'b0;
  logic [5:0]      wr_idx;
  logic [VLEN-1:0] wr_data;
  logic            done;
  logic            err;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [N][N];

  always #10 clk = ~clk;

  acc_xfer u_acc_xfer (.*);

  function automatic logic [31:0] pat(int r, int w);
    return {8'hC3, 8'(r), 8'(w), 8'h5A ^ 8'(r * 7 + w)};
  endfunction

  function automatic logic [VLEN-1:0] reg_img(int r);
    logic [VLEN-1:0] v;
    for (int i = 0; i < N; i++) v[i*32 +: 32] = pat(r, i);
    return v;
  endfunction

  function automatic logic [VLEN-1:0] model_row(int r);
    logic [VLEN-1:0] v;
    for (int i = 0; i < N; i++) v[i*32 +: 32] = model[r][i];
    return v;
  endfunction

  task automatic chk(input bit ok, input string req,
                     input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(cmd_ready == 1'b1, "R1 cmd_ready", VLEN'(cmd_ready), 1);
    chk({done, err, rd_ready, wr_valid} == 4'b0, "R1 idle outputs",
        VLEN'({done, err, rd_ready, wr_valid}), 0);
  endtask

  task automatic t_set(input int base, input bit trans, input bit gap, input string tag);
    int cyc = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_get = 1'b0; cmd_transpose = trans; cmd_base = 6'(base);
    @(posedge clk); #1; cmd_valid = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (gap && k == 3) begin
        @(negedge clk); rd_valid = 1'b0; rd_data = '0; #1;
        chk(rd_ready && rd_idx == 6'(base + k), "R9 stall holds index",
            VLEN'(rd_idx), VLEN'(base + k));
        @(posedge clk); cyc++;
      end
      @(negedge clk);
      rd_valid = 1'b1; rd_data = reg_img(base + k); #1;
      chk(rd_ready && rd_idx == 6'(base + k), {tag, " read index"},
          VLEN'(rd_idx), VLEN'(base + k));
      chk(cmd_ready == 1'b0, "R2 busy not ready", VLEN'(cmd_ready), 0);
      @(posedge clk); cyc++;
      for (int i = 0; i < N; i++) begin
        if (trans) model[i][k] = pat(base + k, i);
        else       model[k][i] = pat(base + k, i);
      end
    end
    @(negedge clk); rd_valid = 1'b0; #1;
    chk(done && cmd_ready, "R8 done with idle", VLEN'({done, cmd_ready}), 3);
    if (!gap) chk(cyc == N, "R11 beat cycles", VLEN'(cyc), VLEN'(N));
    @(negedge clk); #1;
    chk(done == 1'b0, "R8 done one cycle", VLEN'(done), 0);
  endtask

  task automatic t_get(input bit stall, input string tag);
    int cyc = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_get = 1'b1;
    @(posedge clk); #1; cmd_valid = 1'b0; cmd_get = 1'b0;
    for (int r = 0; r < N; r++) begin
      if (stall && r == 2) begin
        @(negedge clk); wr_ready = 1'b0; #1;
        chk(wr_valid && wr_idx == 6'(GB + r) && wr_data == model_row(r),
            "R10 stalled beat", wr_data, model_row(r));
        @(posedge clk); cyc++;
        @(negedge clk); #1;
        chk(wr_valid && wr_idx == 6'(GB + r) && wr_data == model_row(r),
            "R10 held after stall", wr_data, model_row(r));
        @(posedge clk); cyc++;
      end
      @(negedge clk); wr_ready = 1'b1; #1;
      chk(wr_valid && wr_idx == 6'(GB + r), {tag, " write index"},
          VLEN'(wr_idx), VLEN'(GB + r));
      chk(wr_data == model_row(r), {tag, " row data"}, wr_data, model_row(r));
      @(posedge clk); cyc++;
      for (int i = 0; i < N; i++) model[r][i] = '0;
    end
    @(negedge clk); wr_ready = 1'b0; #1;
    chk(done && cmd_ready && !wr_valid, "R8 drain done", VLEN'({done, cmd_ready, wr_valid}), 6);
    if (!stall) chk(cyc == N, "R11 drain cycles", VLEN'(cyc), VLEN'(N));
  endtask

  task automatic t_misaligned();
    @(negedge clk);
    cmd_valid = 1'b1; cmd_get = 1'b0; cmd_transpose = 1'b0; cmd_base = 6'd17;
    @(posedge clk); #1; cmd_valid = 1'b0;
    @(negedge clk); #1;
    chk(err && !done && !rd_ready && cmd_ready, "R7 err pulse",
        VLEN'({err, done, rd_ready, cmd_ready}), 4'b1001);
    @(negedge clk); #1;
    chk(!err && !done && !rd_ready, "R7 err single cycle",
        VLEN'({err, done, rd_ready}), 0);
  endtask

  initial begin
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) model[a][b] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_get(1'b0, "R1 zero after reset");
    t_set(0, 1'b0, 1'b0, "R3");
    t_get(1'b0, "R5");
    t_get(1'b0, "R6 cleared");
    t_set(16, 1'b1, 1'b1, "R4");
    t_misaligned();
    t_get(1'b1, "R7 array unchanged");
    t_set(32, 1'b0, 1'b0, "R3 base 32");
    t_set(0, 1'b1, 1'b0, "R4 overwrite");
    t_get(1'b0, "R4 readout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule